// File: doc/BRIEF.md
# Memory Domain Access Checker

This block sits after a short-descriptor translation walk and decides what happens to each access. Each access arrives with a valid strobe. It carries the first-level descriptor, a flag that says whether the access is a second-level page or a first-level section, the virtual address, and a permission verdict from a separate unit that decodes the access-permission bits. The block reads the 4-bit domain number from the descriptor. It looks up the 2-bit type of that domain in a 32-bit domain control register, which holds 16 two-bit fields and has its own write port. It then reports in the same cycle one of three results: the access proceeds, a domain fault, or a permission fault.

A domain type can block every access to the domain (no access, and the reserved code), enforce the permission verdict (client), or skip the permission verdict (manager). When a valid access faults, the block registers a status word on the next clock edge. The word carries the domain number and a 5-bit fault code that depends on the fault kind and on the translation level. The faulting address is registered at the same edge, and a one-cycle pulse marks the update.

The access port has no back-pressure. An access is taken on every cycle in which its valid strobe is high, and its result is final in that same cycle. A caller that needs to stall must hold valid low. The control register write port and the status outputs are plain signals with no handshake.

Top module: `mem_domain_checker`

## Requirements
- R1: After reset the control register reads as all zeros, so every domain is of type no access. The status word, the fault address and the fault pulse are all zero.
- R2: The domain number of an access is bits [8:5] of the descriptor. Its type is bits [2d+1:2d] of the control register, where d is that domain number.
- R3: Type 2'b00 (no access) raises `dom_fault` in the same cycle as a valid access, whatever the value of `perm_ok`.
- R4: Type 2'b10 (reserved) behaves exactly like type 2'b00.
- R5: Type 2'b01 (client) asserts `acc_ok` when `perm_ok` is 1. When `perm_ok` is 0 it asserts `perm_fault` instead, in the same cycle.
- R6: Type 2'b11 (manager) asserts `acc_ok` in the same cycle whatever the value of `perm_ok`.
- R7: While `acc_valid` is low, `acc_ok`, `dom_fault` and `perm_fault` are all 0, no fault pulse follows, and the status and address registers hold their values.
- R8: A write to the control register takes effect from the next cycle on. An access in the same cycle as the write is judged by the old value.
- R9: The status word is 11 bits wide. Bit 10 is fault-code bit 4, bits [9:8] are 0, bits [7:4] hold the domain number and bits [3:0] are fault-code bits [3:0]. The fault codes are: domain fault on a section 5'b01001, domain fault on a page 5'b01011, permission fault on a section 5'b01101, permission fault on a page 5'b01111. For example, descriptor 0x7EEDC831 used for a page access in a no-access domain 1 gives 0x01B.
- R10: At the clock edge that ends a cycle holding a valid faulting access, the status word and the fault address are loaded and `fault_pulse` is high for one cycle. At every other edge both registers hold and `fault_pulse` is 0.
- R11: In any cycle at most one of `acc_ok`, `dom_fault` and `perm_fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr_en | input | 1 | Write strobe for the domain control register |
| ctl_wr_data | input | 32 | New control register value: 16 two-bit domain types |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_desc | input | 32 | First-level descriptor of the access; domain number in [8:5] |
| acc_page | input | 1 | 1 = second-level page access, 0 = section access |
| acc_addr | input | 32 | Virtual address of the access |
| perm_ok | input | 1 | The permission-check unit allows the access |
| acc_ok | output | 1 | The access proceeds |
| dom_fault | output | 1 | Domain fault on this access |
| perm_fault | output | 1 | Permission fault on this access |
| fault_status | output | 11 | Registered status word of the last fault |
| fault_addr | output | 32 | Registered address of the last fault |
| fault_pulse | output | 1 | One-cycle pulse when the fault registers were just loaded |

## Verification
A control register write and an access can fall in the same cycle, and so can an access and a domain whose type is being changed. The bench provokes this in two ways. First, it reloads the whole register while a manager-domain access is in flight. The same-cycle result must come from the old type, and the next access must see the new no-access type and fault. Second, the bench also loads each new sweep pattern in a cycle with valid low. This checks that the write alone disturbs neither the verdict outputs nor the held fault registers.

// File: rtl/dom_pkg.sv
package dom_pkg;
  typedef enum logic [1:0] {
    DT_BLOCK  = 2'b00,
    DT_CLIENT = 2'b01,
    DT_RSVD   = 2'b10,
    DT_OPEN   = 2'b11
  } dom_type_e;

  localparam logic [4:0] FS_DOM_SECT  = 5'b01001;
  localparam logic [4:0] FS_DOM_PAGE  = 5'b01011;
  localparam logic [4:0] FS_PERM_SECT = 5'b01101;
  localparam logic [4:0] FS_PERM_PAGE = 5'b01111;

  localparam int STAT_W = 11;

  typedef struct packed {
    logic ok;
    logic dom_flt;
    logic perm_flt;
  } verdict_t;
endpackage

// File: rtl/dom_ctl_bank.sv
module dom_ctl_bank #(
  parameter int NUM_DOM = 16,
  parameter int TYPE_W  = 2,
  localparam int CTL_W  = NUM_DOM * TYPE_W,
  localparam int DOM_W  = $clog2(NUM_DOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic [DOM_W-1:0]  sel,
  output logic [TYPE_W-1:0] sel_type
);
  logic [CTL_W-1:0]  ctl_q;
  logic [TYPE_W-1:0] field [NUM_DOM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data;
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign field[g] = ctl_q[g*TYPE_W +: TYPE_W];
  end

  assign sel_type = field[sel];

  // R8: a write is visible from the following cycle on
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == $past(wr_data)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/dom_verdict.sv
module dom_verdict
  import dom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic [1:0] dtype,
  input  logic       perm_ok,
  input  logic       is_page,
  output verdict_t   vd,
  output logic [4:0] fs_code
);
  dom_type_e t;
  assign t = dom_type_e'(dtype);

  always_comb begin
    vd = '0;
    if (valid) begin
      unique case (t)
        DT_OPEN:   vd.ok = 1'b1;
        DT_CLIENT: begin
          vd.ok       = perm_ok;
          vd.perm_flt = !perm_ok;
        end
        default:   vd.dom_flt = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (vd.perm_flt) fs_code = is_page ? FS_PERM_PAGE : FS_PERM_SECT;
    else             fs_code = is_page ? FS_DOM_PAGE  : FS_DOM_SECT;
  end

  assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && dtype == 2'b00) |-> (vd.dom_flt && !vd.ok));
  assert_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && dtype == 2'b10) |-> (vd.dom_flt && !vd.ok));
  assert_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && dtype == 2'b11) |-> vd.ok);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (vd == '0));
  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vd.ok, vd.dom_flt, vd.perm_flt}));
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import dom_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DOM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [4:0]        fs_code,
  input  logic [DOM_W-1:0]  dom,
  input  logic [ADDR_W-1:0] addr,
  output logic [STAT_W-1:0] status,
  output logic [ADDR_W-1:0] addr_q,
  output logic              pulse
);
  logic [STAT_W-1:0] stat_next;

  always_comb begin
    stat_next           = '0;
    stat_next[3:0]      = fs_code[3:0];
    stat_next[4 +: DOM_W] = dom;
    stat_next[10]       = fs_code[4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      addr_q <= '0;
      pulse  <= 1'b0;
    end else begin
      pulse <= load;
      if (load) begin
        status <= stat_next;
        addr_q <= addr;
      end
    end
  end

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pulse);
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !pulse);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |-> ($stable(status) && $stable(addr_q)));
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (status[9:8] == 2'b00));
endmodule

// File: rtl/mem_domain_checker.sv
module mem_domain_checker
  import dom_pkg::*;
#(
  parameter int NUM_DOM = 16,
  parameter int ADDR_W  = 32,
  parameter int DESC_W  = 32,
  parameter int DOM_LSB = 5,
  localparam int TYPE_W = 2,
  localparam int CTL_W  = NUM_DOM * TYPE_W,
  localparam int DOM_W  = $clog2(NUM_DOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  input  logic              acc_valid,
  input  logic [DESC_W-1:0] acc_desc,
  input  logic              acc_page,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              perm_ok,
  output logic              acc_ok,
  output logic              dom_fault,
  output logic              perm_fault,
  output logic [STAT_W-1:0] fault_status,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              fault_pulse
);
  logic [DOM_W-1:0]  dom_num;
  logic [TYPE_W-1:0] dtype;
  verdict_t          vd;
  logic [4:0]        fs_code;

  assign dom_num = acc_desc[DOM_LSB +: DOM_W];

  dom_ctl_bank #(.NUM_DOM(NUM_DOM), .TYPE_W(TYPE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .sel(dom_num), .sel_type(dtype)
  );

  dom_verdict u_vd (
    .clk(clk), .rst_n(rst_n), .valid(acc_valid), .dtype(dtype),
    .perm_ok(perm_ok), .is_page(acc_page), .vd(vd), .fs_code(fs_code)
  );

  fault_capture #(.ADDR_W(ADDR_W), .DOM_W(DOM_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(vd.dom_flt | vd.perm_flt),
    .fs_code(fs_code), .dom(dom_num), .addr(acc_addr),
    .status(fault_status), .addr_q(fault_addr), .pulse(fault_pulse)
  );

  assign acc_ok     = vd.ok;
  assign dom_fault  = vd.dom_flt;
  assign perm_fault = vd.perm_flt;

  // R10: a faulting valid access is followed by a pulse carrying its address
  assert_fault_to_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (dom_fault || perm_fault)) |=>
      (fault_pulse && fault_addr == $past(acc_addr)));
  // R9: recorded domain equals the descriptor field of the faulting access
  assert_dom_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (dom_fault || perm_fault)) |=>
      (fault_status[4 +: DOM_W] == $past(acc_desc[DOM_LSB +: DOM_W])));
endmodule

// File: tb/sim_mem_domain_checker.sv
module sim_mem_domain_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic        acc_valid;
  logic [31:0] acc_desc;
  logic        acc_page;
  logic [31:0] acc_addr;
  logic        perm_ok;
  logic        acc_ok, dom_fault, perm_fault, fault_pulse;
  logic [10:0] fault_status;
  logic [31:0] fault_addr;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_ctl;
  logic [10:0] m_stat;
  logic [31:0] m_addr;

  always #4 clk = ~clk;

  mem_domain_checker u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .acc_valid(acc_valid), .acc_desc(acc_desc), .acc_page(acc_page),
    .acc_addr(acc_addr), .perm_ok(perm_ok), .acc_ok(acc_ok),
    .dom_fault(dom_fault), .perm_fault(perm_fault),
    .fault_status(fault_status), .fault_addr(fault_addr),
    .fault_pulse(fault_pulse)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one access, optionally with a control write in the same cycle
  task automatic access(input logic [31:0] desc, input logic page,
                        input logic perm, input logic valid,
                        input logic [31:0] addr, input logic wr,
                        input logic [31:0] wdata);
    logic [3:0] d;
    logic [1:0] t;
    logic eok, edf, epf;
    logic [4:0] fs;
    string rq;
    @(negedge clk);
    acc_desc = desc; acc_page = page; perm_ok = perm; acc_valid = valid;
    acc_addr = addr; ctl_wr_en = wr; ctl_wr_data = wdata;
    d = desc[8:5];                      // R2 field position
    t = m_ctl[2*d +: 2];                // R2 type lookup, old value (R8)
    eok = valid && (t == 2'b11 || (t == 2'b01 && perm));
    edf = valid && (t == 2'b00 || t == 2'b10);
    epf = valid && t == 2'b01 && !perm;
    if (!valid)          rq = "R7";
    else if (t == 2'b00) rq = "R3";
    else if (t == 2'b10) rq = "R4";
    else if (t == 2'b01) rq = "R5";
    else                 rq = "R6";
    #1;
    chk(rq, "acc_ok", 32'(acc_ok), 32'(eok));
    chk(rq, "dom_fault", 32'(dom_fault), 32'(edf));
    chk(rq, "perm_fault", 32'(perm_fault), 32'(epf));
    chk("R11", "onehot", 32'($countones({acc_ok, dom_fault, perm_fault}) <= 1), 32'd1);
    if (edf || epf) begin
      fs = edf ? (page ? 5'b01011 : 5'b01001) : (page ? 5'b01111 : 5'b01101);
      m_stat = {fs[4], 2'b00, d, fs[3:0]};
      m_addr = addr;
    end
    @(posedge clk);
    if (wr) m_ctl = wdata;
    #1;
    chk("R10", "fault_pulse", 32'(fault_pulse), 32'(edf || epf));
    chk("R9", "fault_status", 32'(fault_status), 32'(m_stat));
    chk("R10", "fault_addr", fault_addr, m_addr);
    ctl_wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0; acc_valid = 1'b0;
    acc_desc = '0; acc_page = 1'b0; acc_addr = '0; perm_ok = 1'b0;
    m_ctl = '0; m_stat = '0; m_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "fault_status", 32'(fault_status), 32'h0);
    chk("R1", "fault_addr", fault_addr, 32'h0);
    chk("R1", "fault_pulse", 32'(fault_pulse), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 + R9: reset value makes domain 1 no access; page domain fault = 0x01B
    access(32'h7EEDC831, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 32'h0);
    chk("R9", "example status 0x01B", 32'(fault_status), 32'h01B);
    access(32'h7EEDC831, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 32'h0);

    // sweep: every domain sees every type across four patterns
    for (int k = 0; k < 4; k++) begin
      pat = '0;
      for (int d = 0; d < 16; d++) pat[2*d +: 2] = 2'((d + k) % 4);
      // write with valid low: R7 no outputs, registers hold
      access(32'h0000_0001, 1'b0, 1'b0, 1'b0, 32'hDEAD_0000, 1'b1, pat);
      for (int d = 0; d < 16; d++)
        for (int pg = 0; pg < 2; pg++)
          for (int pm = 0; pm < 2; pm++)
            access({23'(32'h5A5A5 * (d + 1) + k), 4'(d), 3'(pm * 5 + pg), 2'b01},
                   1'(pg), 1'(pm), 1'b1,
                   32'h1000_0000 + 32'(k * 256 + d * 16 + pg * 4 + pm),
                   1'b0, 32'h0);
    end

    // R8: domain 0 is manager (k=3); clear everything while accessing it
    access(32'hFFFF_FE01, 1'b0, 1'b0, 1'b1, 32'hCAFE_0001, 1'b1, 32'h0);
    chk("R8", "old type governs same cycle", 32'(m_ctl), 32'h0);
    access(32'hFFFF_FE01, 1'b1, 1'b0, 1'b1, 32'hCAFE_0002, 1'b0, 32'h0);
    // R7: no-access domain with valid low leaves everything untouched
    access(32'hFFFF_FE01, 1'b1, 1'b0, 1'b0, 32'hBAD0_BAD0, 1'b0, 32'h0);
    // R8: set only domain 15 to client, check next cycle
    access(32'h0000_01E1, 1'b1, 1'b1, 1'b1, 32'hCAFE_0003, 1'b1, 32'h4000_0000);
    access(32'h0000_01E1, 1'b1, 1'b1, 1'b1, 32'hCAFE_0004, 1'b0, 32'h0);
    access(32'h0000_01E1, 1'b1, 1'b0, 1'b1, 32'hCAFE_0005, 1'b0, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule